// File: doc/BRIEF.md
# Single-Bus Register Datapath for a 16-bit Accumulator Machine

This block is the register file and shared bus of a small accumulator machine. Six registers (address, program counter, data, accumulator, instruction and temporary) plus the external memory word can each drive a single 16-bit bus. Exactly one source is picked per cycle by a 3-bit select code. That code is derived from seven one-hot request lines by a plain OR encoder, with no priority between them. Registers that need it accept clear, load and increment strobes on the clock edge. The instruction and output registers accept only a load.

The control sequencer and the arithmetic unit live outside the block. The sequencer raises the request line for the bus source and the per-register strobes in the same cycle. The accumulator loads from a dedicated result input supplied by the arithmetic unit. An 8-bit input character register is kept here and is presented to that unit. The memory array is also external: the address register is its address, the bus is its write data, and its read data is the seventh bus source.

Top module: `bus_datapath`

## Requirements
- R1: Request line k (bit k-1 of `src_req`, k=1..7) yields select code k and puts its source on the bus: 1 address reg, 2 program counter, 3 data reg, 4 accumulator, 5 instruction reg, 6 temporary reg, 7 memory read data. At most one request line is active in any cycle.
- R2: With no request line active, the select code is 000 and the bus reads zero.
- R3: The 12-bit address register and program counter appear on the bus with bits 15..12 equal to zero.
- R4: The output register loads bus bits 7..0 when `outr_ld` is high and holds its value otherwise.
- R5: For the address reg, program counter, data reg, accumulator and temporary reg, clear beats load, and load beats increment. With no strobe active the register holds its value.
- R6: An increment wraps at the register's own width: 0xFFF goes to 0x000 for the 12-bit registers, and 0xFFFF goes to 0x0000 for the 16-bit ones.
- R7: A register load captures the bus value present before the clock edge. One register can therefore drive the bus while another register loads it and the driver itself is incremented or cleared in the same cycle.
- R8: The instruction register loads the full bus word on `ir_ld` and holds its value otherwise.
- R9: `mem_addr` equals the address register, `mem_wdata` equals the bus, and `mem_we` follows `mem_wr`.
- R10: While `rst_n` is low, every register reads zero.
- R11: The accumulator loads from `ac_din`, not from the bus. The input register loads `inpr_din` on `inpr_ld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 7 | One-hot bus source requests, bit 0 = address reg .. bit 6 = memory |
| ar_ld | input | 1 | Address reg load from bus |
| ar_inc | input | 1 | Address reg increment |
| ar_clr | input | 1 | Address reg clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inc | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data reg load from bus |
| dr_inc | input | 1 | Data reg increment |
| dr_clr | input | 1 | Data reg clear |
| ac_ld | input | 1 | Accumulator load from `ac_din` |
| ac_inc | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| tr_ld | input | 1 | Temporary reg load from bus |
| tr_inc | input | 1 | Temporary reg increment |
| tr_clr | input | 1 | Temporary reg clear |
| ir_ld | input | 1 | Instruction reg load from bus |
| outr_ld | input | 1 | Output reg load from bus low byte |
| inpr_ld | input | 1 | Input reg load from `inpr_din` |
| inpr_din | input | 8 | Character from the input device |
| ac_din | input | 16 | Arithmetic unit result for the accumulator |
| mem_rdata | input | 16 | Memory read data |
| mem_wr | input | 1 | Memory write request |
| mem_addr | output | 12 | Memory address (address reg) |
| mem_wdata | output | 16 | Memory write data (bus) |
| mem_we | output | 1 | Memory write strobe |
| bus_sel | output | 3 | Encoded bus select code |
| bus_q | output | 16 | Bus value |
| ar_q | output | 12 | Address reg |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data reg |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction reg |
| tr_q | output | 16 | Temporary reg |
| outr_q | output | 8 | Output character reg |
| inpr_q | output | 8 | Input character reg |

## Verification
Two kinds of same-cycle overlap matter here. The first is a register driving the bus while another register, or the driver itself, changes at the same edge. The bench provokes this by letting the address register drive the bus while the program counter loads it and the address register increments. It also lets the temporary register feed the data register while the temporary register is cleared. The loaded value must equal the driver's value from before the edge. The second overlap is clear, load and increment arriving together on one register. A sweep applies all eight strobe combinations to each of the five multi-function registers, and the bench compares the result with the value its own priority rule predicts.

// File: rtl/bdp_pkg.sv
`timescale 1ns/1ps
package bdp_pkg;
  // Bus select codes; the code value equals the request line number.
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  localparam int NUM_SRC = 7;
  localparam int SEL_W   = 3;
endpackage

// File: rtl/bdp_src_enc.sv
`timescale 1ns/1ps
module bdp_src_enc
  import bdp_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic [SEL_W-1:0]   sel
);
  // Priority-free: each active line ORs its own number into the code.
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i]) sel = sel | SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/bdp_bus_mux.sv
`timescale 1ns/1ps
module bdp_bus_mux
  import bdp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [WORD_W-1:0] dr,
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] ir,
  input  logic [WORD_W-1:0] tr,
  input  logic [WORD_W-1:0] mem,
  output logic [WORD_W-1:0] bus
);
  localparam int PAD_W = WORD_W - ADDR_W;

  function automatic logic [WORD_W-1:0] zext_addr(input logic [ADDR_W-1:0] a);
    return {{PAD_W{1'b0}}, a};
  endfunction

  always_comb begin
    case (bus_src_e'(sel))
      SRC_AR:  bus = zext_addr(ar);
      SRC_PC:  bus = zext_addr(pc);
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/bdp_reg.sv
`timescale 1ns/1ps
module bdp_reg #(
  parameter int W    = 16,
  parameter bit FULL = 1'b1   // 1: clear/load/increment, 0: load only
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Clear first, then load, then increment; wraps at W bits.
  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic [W-1:0] din,
                                            input logic l, input logic i,
                                            input logic c);
    if (c)      return '0;
    else if (l) return din;
    else if (i) return cur + W'(1);
    else        return cur;
  endfunction

  generate
    if (FULL) begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_val(q, d, ld, inc, clr);
      end
    end else begin : g_load_only
      logic unused_ctl;
      assign unused_ctl = inc | clr;
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/bus_datapath.sv
`timescale 1ns/1ps
module bus_datapath
  import bdp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        src_req,
  input  logic              ar_ld,
  input  logic              ar_inc,
  input  logic              ar_clr,
  input  logic              pc_ld,
  input  logic              pc_inc,
  input  logic              pc_clr,
  input  logic              dr_ld,
  input  logic              dr_inc,
  input  logic              dr_clr,
  input  logic              ac_ld,
  input  logic              ac_inc,
  input  logic              ac_clr,
  input  logic              tr_ld,
  input  logic              tr_inc,
  input  logic              tr_clr,
  input  logic              ir_ld,
  input  logic              outr_ld,
  input  logic              inpr_ld,
  input  logic [CHAR_W-1:0] inpr_din,
  input  logic [WORD_W-1:0] ac_din,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [2:0]        bus_sel,
  output logic [WORD_W-1:0] bus_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [WORD_W-1:0] dr_q,
  output logic [WORD_W-1:0] ac_q,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] tr_q,
  output logic [CHAR_W-1:0] outr_q,
  output logic [CHAR_W-1:0] inpr_q
);
  // Named internal wires, visible to the bound checker.
  logic [SEL_W-1:0]  sel_w;
  logic [WORD_W-1:0] bus_w;

  bdp_src_enc u_enc (
    .req (src_req),
    .sel (sel_w)
  );

  bdp_bus_mux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mux (
    .sel (sel_w),
    .ar  (ar_q),
    .pc  (pc_q),
    .dr  (dr_q),
    .ac  (ac_q),
    .ir  (ir_q),
    .tr  (tr_q),
    .mem (mem_rdata),
    .bus (bus_w)
  );

  bdp_reg #(.W(ADDR_W), .FULL(1'b1)) u_ar (
    .clk(clk), .rst_n(rst_n), .ld(ar_ld), .inc(ar_inc), .clr(ar_clr),
    .d(bus_w[ADDR_W-1:0]), .q(ar_q)
  );

  bdp_reg #(.W(ADDR_W), .FULL(1'b1)) u_pc (
    .clk(clk), .rst_n(rst_n), .ld(pc_ld), .inc(pc_inc), .clr(pc_clr),
    .d(bus_w[ADDR_W-1:0]), .q(pc_q)
  );

  bdp_reg #(.W(WORD_W), .FULL(1'b1)) u_dr (
    .clk(clk), .rst_n(rst_n), .ld(dr_ld), .inc(dr_inc), .clr(dr_clr),
    .d(bus_w), .q(dr_q)
  );

  bdp_reg #(.W(WORD_W), .FULL(1'b1)) u_ac (
    .clk(clk), .rst_n(rst_n), .ld(ac_ld), .inc(ac_inc), .clr(ac_clr),
    .d(ac_din), .q(ac_q)
  );

  bdp_reg #(.W(WORD_W), .FULL(1'b1)) u_tr (
    .clk(clk), .rst_n(rst_n), .ld(tr_ld), .inc(tr_inc), .clr(tr_clr),
    .d(bus_w), .q(tr_q)
  );

  bdp_reg #(.W(WORD_W), .FULL(1'b0)) u_ir (
    .clk(clk), .rst_n(rst_n), .ld(ir_ld), .inc(1'b0), .clr(1'b0),
    .d(bus_w), .q(ir_q)
  );

  bdp_reg #(.W(CHAR_W), .FULL(1'b0)) u_outr (
    .clk(clk), .rst_n(rst_n), .ld(outr_ld), .inc(1'b0), .clr(1'b0),
    .d(bus_w[CHAR_W-1:0]), .q(outr_q)
  );

  bdp_reg #(.W(CHAR_W), .FULL(1'b0)) u_inpr (
    .clk(clk), .rst_n(rst_n), .ld(inpr_ld), .inc(1'b0), .clr(1'b0),
    .d(inpr_din), .q(inpr_q)
  );

  assign bus_sel   = sel_w;
  assign bus_q     = bus_w;
  assign mem_addr  = ar_q;
  assign mem_wdata = bus_w;
  assign mem_we    = mem_wr;
endmodule

// File: rtl/bdp_checker.sv
`timescale 1ns/1ps
module bdp_checker #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        src_req,
  input logic [2:0]        bus_sel,
  input logic [WORD_W-1:0] bus_q,
  input logic [ADDR_W-1:0] ar_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [WORD_W-1:0] ir_q,
  input logic [CHAR_W-1:0] outr_q,
  input logic              ar_ld,
  input logic              ar_clr,
  input logic              pc_ld,
  input logic              pc_inc,
  input logic              pc_clr,
  input logic              ir_ld,
  input logic              outr_ld
);
  assert_onehot_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_req));

  assert_idle_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 7'd0) |-> (bus_sel == 3'd0 && bus_q == '0));

  assert_ar_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 7'b0000001) |-> (bus_q == {{(WORD_W-ADDR_W){1'b0}}, ar_q}));

  assert_pc_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == 7'b0000010) |-> (bus_q == {{(WORD_W-ADDR_W){1'b0}}, pc_q}));

  assert_outr_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outr_ld |=> (outr_q == $past(bus_q[CHAR_W-1:0])));

  assert_clr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ar_clr |=> (ar_q == '0));

  assert_pc_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_ld && !pc_clr) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  assert_pre_edge_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_ld && !ar_clr) |=> (ar_q == $past(bus_q[ADDR_W-1:0])));

  assert_ir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_ld |=> $stable(ir_q));
endmodule

bind bus_datapath bdp_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_sel(bus_sel),
  .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q), .ir_q(ir_q), .outr_q(outr_q),
  .ar_ld(ar_ld), .ar_clr(ar_clr), .pc_ld(pc_ld), .pc_inc(pc_inc),
  .pc_clr(pc_clr), .ir_ld(ir_ld), .outr_ld(outr_ld)
);

// File: tb/tb_bus_datapath.sv
`timescale 1ns/1ps
module tb_bus_datapath;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [6:0]  src_req;
  logic        ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr;
  logic        dr_ld, dr_inc, dr_clr, ac_ld, ac_inc, ac_clr;
  logic        tr_ld, tr_inc, tr_clr, ir_ld, outr_ld, inpr_ld;
  logic [7:0]  inpr_din;
  logic [15:0] ac_din, mem_rdata;
  logic        mem_wr;
  logic [11:0] mem_addr, ar_q, pc_q;
  logic [15:0] mem_wdata, bus_q, dr_q, ac_q, ir_q, tr_q;
  logic        mem_we;
  logic [2:0]  bus_sel;
  logic [7:0]  outr_q, inpr_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bus_datapath dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .ar_ld(ar_ld), .ar_inc(ar_inc), .ar_clr(ar_clr),
    .pc_ld(pc_ld), .pc_inc(pc_inc), .pc_clr(pc_clr),
    .dr_ld(dr_ld), .dr_inc(dr_inc), .dr_clr(dr_clr),
    .ac_ld(ac_ld), .ac_inc(ac_inc), .ac_clr(ac_clr),
    .tr_ld(tr_ld), .tr_inc(tr_inc), .tr_clr(tr_clr),
    .ir_ld(ir_ld), .outr_ld(outr_ld), .inpr_ld(inpr_ld),
    .inpr_din(inpr_din), .ac_din(ac_din), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .bus_sel(bus_sel), .bus_q(bus_q),
    .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q),
    .tr_q(tr_q), .outr_q(outr_q), .inpr_q(inpr_q)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_req = '0; mem_wr = 1'b0;
    {ar_ld, ar_inc, ar_clr, pc_ld, pc_inc, pc_clr} = '0;
    {dr_ld, dr_inc, dr_clr, ac_ld, ac_inc, ac_clr} = '0;
    {tr_ld, tr_inc, tr_clr, ir_ld, outr_ld, inpr_ld} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // r: 0 AR, 1 PC, 2 DR, 3 AC, 4 TR
  task automatic set_ctl(input int r, input logic l, input logic i, input logic c);
    case (r)
      0: begin ar_ld = l; ar_inc = i; ar_clr = c; end
      1: begin pc_ld = l; pc_inc = i; pc_clr = c; end
      2: begin dr_ld = l; dr_inc = i; dr_clr = c; end
      3: begin ac_ld = l; ac_inc = i; ac_clr = c; end
      default: begin tr_ld = l; tr_inc = i; tr_clr = c; end
    endcase
  endtask

  function automatic logic [15:0] get_q(input int r);
    case (r)
      0: return {4'h0, ar_q};
      1: return {4'h0, pc_q};
      2: return dr_q;
      3: return ac_q;
      default: return tr_q;
    endcase
  endfunction

  // Load one of the five multi-function registers (memory via bus, AC via ac_din).
  task automatic load(input int r, input logic [15:0] v);
    idle();
    mem_rdata = v; ac_din = v; src_req = 7'b1000000;
    set_ctl(r, 1'b1, 1'b0, 1'b0);
    tick();
    idle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] expv [7];
    logic [15:0] mask, base, ldv, e;
    idle();
    rst_n = 1'b0; inpr_din = '0; ac_din = '0; mem_rdata = '0;
    repeat (3) tick();
    // R10: reset state
    chk("R10 ar", {4'h0, ar_q}, 16'h0);
    chk("R10 pc", {4'h0, pc_q}, 16'h0);
    chk("R10 dr", dr_q, 16'h0);
    chk("R10 ac", ac_q, 16'h0);
    chk("R10 ir", ir_q, 16'h0);
    chk("R10 tr", tr_q, 16'h0);
    chk("R10 outr/inpr", {outr_q, inpr_q}, 16'h0);
    rst_n = 1'b1;
    tick();

    // R2: idle bus
    mem_rdata = 16'hFFFF; src_req = '0; #1;
    chk("R2 sel", {13'h0, bus_sel}, 16'h0);
    chk("R2 bus", bus_q, 16'h0);

    // Preload distinct values
    load(0, 16'h79C3);
    load(1, 16'hF0A5);
    load(2, 16'h1234);
    load(3, 16'h8001);
    load(4, 16'h5A5A);
    mem_rdata = 16'hCAFE; src_req = 7'b1000000; ir_ld = 1'b1; tick(); idle();
    chk("R8 ir load", ir_q, 16'hCAFE);
    mem_rdata = 16'h0F0F;

    // R1 / R3: sweep every source
    expv[0] = 16'h09C3; expv[1] = 16'h00A5; expv[2] = 16'h1234; expv[3] = 16'h8001;
    expv[4] = 16'hCAFE; expv[5] = 16'h5A5A; expv[6] = 16'h0F0F;
    for (int i = 0; i < 7; i++) begin
      src_req = 7'(1 << i); #1;
      chk("R1 sel", {13'h0, bus_sel}, 16'(i + 1));
      chk((i < 2) ? "R3 bus zext" : "R1 bus", bus_q, expv[i]);
    end
    idle(); #1;

    // R9: memory port
    src_req = 7'b0000001; mem_wr = 1'b1; #1;
    chk("R9 addr", {4'h0, mem_addr}, 16'h09C3);
    chk("R9 wdata", mem_wdata, 16'h09C3);
    chk("R9 we", {15'h0, mem_we}, 16'h1);
    idle(); #1;
    chk("R9 we low", {15'h0, mem_we}, 16'h0);

    // R4: output reg low byte, then hold
    src_req = 7'b0000100; outr_ld = 1'b1; tick(); idle();
    chk("R4 outr load", {8'h0, outr_q}, 16'h0034);
    src_req = 7'b0010000; tick(); idle();
    chk("R4 outr hold", {8'h0, outr_q}, 16'h0034);

    // R8: instruction reg hold, then load
    src_req = 7'b0000100; tick();
    chk("R8 ir hold", ir_q, 16'hCAFE);
    ir_ld = 1'b1; tick(); idle();
    chk("R8 ir load dr", ir_q, 16'h1234);

    // R11: input reg and accumulator source
    inpr_din = 8'h5C; inpr_ld = 1'b1; tick(); idle();
    chk("R11 inpr", {8'h0, inpr_q}, 16'h005C);
    inpr_din = 8'hAA; tick();
    chk("R11 inpr hold", {8'h0, inpr_q}, 16'h005C);
    ac_din = 16'hBEEF; mem_rdata = 16'h1111; src_req = 7'b1000000; ac_ld = 1'b1; tick(); idle();
    chk("R11 ac from ac_din", ac_q, 16'hBEEF);
    src_req = 7'b0001000; #1;
    chk("R11 ac on bus", bus_q, 16'hBEEF);
    idle();

    // R7: same-cycle drive and load
    src_req = 7'b0000001; pc_ld = 1'b1; ar_inc = 1'b1; tick(); idle();
    chk("R7 pc got old ar", {4'h0, pc_q}, 16'h09C3);
    chk("R7 ar incremented", {4'h0, ar_q}, 16'h09C4);
    src_req = 7'b0100000; dr_ld = 1'b1; tr_clr = 1'b1; tick(); idle();
    chk("R7 dr got old tr", dr_q, 16'h5A5A);
    chk("R7 tr cleared", tr_q, 16'h0000);

    // R5: all strobe combinations on every multi-function register
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 8; c++) begin
        load(r, 16'hE123);
        mask = (r < 2) ? 16'h0FFF : 16'hFFFF;
        base = 16'hE123 & mask;
        ldv  = 16'h0456;
        mem_rdata = ldv; ac_din = ldv; src_req = 7'b1000000;
        set_ctl(r, c[1], c[0], c[2]);
        tick(); idle();
        if (c[2])      e = 16'h0;
        else if (c[1]) e = ldv & mask;
        else if (c[0]) e = (base + 16'h1) & mask;
        else           e = base;
        chk("R5 clr>ld>inc", get_q(r), e);
      end
    end

    // R6: increment wrap
    for (int r = 0; r < 5; r++) begin
      load(r, 16'hFFFF);
      set_ctl(r, 1'b0, 1'b1, 1'b0);
      tick(); idle();
      chk("R6 wrap", get_q(r), 16'h0000);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule